// File: doc/BRIEF.md
# Three-Channel Match Timer with Safe Count Capture

This block holds a bank of independent up-counting timers behind a small word-addressed register bus. Every timer has its own set of match comparators, a reload value and a small selector that chooses which comparator, if any, sends the counter back to the reload value when the count reaches it. A single enable register starts and stops each timer separately. A stopped timer keeps its count, and enabling it again continues from that value.

Every comparator hit sets a sticky flag. Software clears a flag by writing 1 to its bit. To read a running counter without sampling a value that is still changing, software writes a request to that timer's capture register. It then polls a pending bit until the block has taken a copy of the count, and reads the copy from the capture register.

Bus writes take effect on the rising clock edge where `bus_wr` is high. Reads are combinational from the current register state.

Top module: `match_timer_bank`

## Requirements
- R1: After reset, every count, capture, match, reload value, selector, enable bit, flag and pending bit reads 0.
- R2: A timer whose enable bit is 1 adds 1 to its count on every clock edge. A timer whose enable bit is 0 holds its count. Enabling it again resumes from the held value.
- R3: With selector 0 a timer never reloads, and it steps from 0xFFFFFFFF to 0.
- R4: With selector k (1 to 3), an enabled timer whose count equals its match register k-1 loads its reload value on the next edge instead of adding 1.
- R5: Enable bit t controls timer t only. The other timers keep counting or holding as before.
- R6: Flag bit 3*t+i becomes 1 on the edge after a cycle in which timer t is enabled and its count equals match register i. It stays 1 until it is cleared.
- R7: A write to the flag register clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R8: A write with data bit 0 set to the capture register of timer t sets pending bit t for exactly 2 cycles. The capture register then holds the count the timer had one clock after the request edge. A request made while a capture is already pending is ignored.
- R9: The capture register returns the last completed capture, including while a new one is pending. A capture write with data bit 0 clear has no effect. Writes to the live count addresses are ignored.
- R10: The word address map is:
  - 0 to 8: match registers, at address 3*t+i.
  - 9 to 11: live counts.
  - 12 to 14: capture registers.
  - 15 to 17: reload values.
  - 18 to 20: 2-bit selectors.
  - 21: enable register, bit t for timer t.
  - 22: flag register.
  - 23: pending register, bit t for timer t.
  
  Writable registers read back what was written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
A write issued on edge P changes the register, enable or selector state immediately after P. A counter that was enabled at P steps first on edge P+1, so k edges of enable give exactly k steps. The bench therefore separates its enable and disable writes by a counted number of edges and reads the count only after the timer has stopped. A capture request accepted at P reads pending after P and after P+1, and completes at P+2 with the count as it stood after P+1. The bench samples pending and the capture register 1 ns after those exact edges, so each value is checked on the cycle it becomes due.

// File: rtl/mtb_pkg.sv
package mtb_pkg;

    // Address regions, in map order.
    typedef enum int {
        RG_MATCH,
        RG_COUNT,
        RG_SNAP,
        RG_PRE,
        RG_CTRL,
        RG_EN,
        RG_FLAG,
        RG_PEND
    } region_e;

    // First word address of a region, for a given timer and comparator count.
    function automatic int region_base(region_e r, int ntmr, int ncmp);
        case (r)
            RG_MATCH: return 0;
            RG_COUNT: return ntmr * ncmp;
            RG_SNAP:  return ntmr * ncmp + ntmr;
            RG_PRE:   return ntmr * ncmp + 2 * ntmr;
            RG_CTRL:  return ntmr * ncmp + 3 * ntmr;
            RG_EN:    return ntmr * ncmp + 4 * ntmr;
            RG_FLAG:  return ntmr * ncmp + 4 * ntmr + 1;
            default:  return ntmr * ncmp + 4 * ntmr + 2;
        endcase
    endfunction

endpackage

// File: rtl/mtb_channel.sv
// One up-counter with a selectable reload comparator.
module mtb_channel #(
    parameter int CNT_W   = 32,
    parameter int NUM_CMP = 3,
    parameter int CTRL_W  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic [CTRL_W-1:0]               sel,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   match,
    input  logic [CNT_W-1:0]                preload,
    output logic [CNT_W-1:0]                cnt,
    output logic [NUM_CMP-1:0]              hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        int idx;
        s_d = s_q;
        idx = int'(sel) - 1;
        for (int i = 0; i < NUM_CMP; i++) begin
            hit[i] = en && (s_q.cnt == match[i]);
        end
        if (en) begin
            if (idx >= 0 && idx < NUM_CMP && hit[idx]) begin
                s_d.cnt = preload;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/mtb_snap.sv
// Request-then-capture holding register with a fixed synchronisation delay.
module mtb_snap #(
    parameter int CNT_W    = 32,
    parameter int SYNC_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] cnt,
    output logic             pend,
    output logic [CNT_W-1:0] cap
);
    localparam int REM_W = $clog2(SYNC_CYC + 1);

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic [CNT_W-1:0] cap;
    } snap_t;

    snap_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.rem == '0) begin
            if (req) s_d.rem = REM_W'(SYNC_CYC);
        end else begin
            s_d.rem = s_q.rem - REM_W'(1);
            if (s_q.rem == REM_W'(1)) s_d.cap = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = (s_q.rem != '0);
    assign cap  = s_q.cap;
endmodule

// File: rtl/match_timer_bank.sv
module match_timer_bank #(
    parameter int CNT_W    = 32,
    parameter int NUM_TMR  = 3,
    parameter int NUM_CMP  = 3,
    parameter int ADDR_W   = 6,
    parameter int SYNC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata
);
    import mtb_pkg::*;

    localparam int NUM_MATCH = NUM_TMR * NUM_CMP;
    localparam int CTRL_W    = $clog2(NUM_CMP + 1);
    localparam int A_MATCH   = region_base(RG_MATCH, NUM_TMR, NUM_CMP);
    localparam int A_COUNT   = region_base(RG_COUNT, NUM_TMR, NUM_CMP);
    localparam int A_SNAP    = region_base(RG_SNAP,  NUM_TMR, NUM_CMP);
    localparam int A_PRE     = region_base(RG_PRE,   NUM_TMR, NUM_CMP);
    localparam int A_CTRL    = region_base(RG_CTRL,  NUM_TMR, NUM_CMP);
    localparam int A_EN      = region_base(RG_EN,    NUM_TMR, NUM_CMP);
    localparam int A_FLAG    = region_base(RG_FLAG,  NUM_TMR, NUM_CMP);
    localparam int A_PEND    = region_base(RG_PEND,  NUM_TMR, NUM_CMP);

    typedef struct packed {
        logic [NUM_MATCH-1:0][CNT_W-1:0] match;
        logic [NUM_TMR-1:0][CNT_W-1:0]   pre;
        logic [NUM_TMR-1:0][CTRL_W-1:0]  ctrl;
        logic [NUM_TMR-1:0]              en;
        logic [NUM_MATCH-1:0]            flag;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_TMR-1:0][CNT_W-1:0] cap_all;
    logic [NUM_TMR-1:0]            pend_all;
    logic [NUM_TMR-1:0]            snap_req;
    logic [NUM_MATCH-1:0]          hit_all;
    logic [NUM_TMR-1:0]            tmr_en;
    logic [NUM_TMR-1:0][CTRL_W-1:0] tmr_ctrl;
    logic [NUM_MATCH-1:0]          flag_all;

    assign tmr_en   = r_q.en;
    assign tmr_ctrl = r_q.ctrl;
    assign flag_all = r_q.flag;

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        mtb_channel #(
            .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .CTRL_W(CTRL_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (r_q.en[t]),
            .sel     (r_q.ctrl[t]),
            .match   (r_q.match[t*NUM_CMP +: NUM_CMP]),
            .preload (r_q.pre[t]),
            .cnt     (cnt_all[t]),
            .hit     (hit_all[t*NUM_CMP +: NUM_CMP])
        );

        mtb_snap #(
            .CNT_W(CNT_W), .SYNC_CYC(SYNC_CYC)
        ) u_snap (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (snap_req[t]),
            .cnt   (cnt_all[t]),
            .pend  (pend_all[t]),
            .cap   (cap_all[t])
        );
    end

    // Next-state of the register file and capture requests.
    always_comb begin
        int a;
        logic [NUM_MATCH-1:0] clr;
        a   = int'(bus_addr);
        r_d = r_q;
        clr = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            snap_req[t] = bus_wr && (a == A_SNAP + t) && bus_wdata[0];
        end
        if (bus_wr) begin
            for (int m = 0; m < NUM_MATCH; m++) begin
                if (a == A_MATCH + m) r_d.match[m] = bus_wdata;
            end
            for (int t = 0; t < NUM_TMR; t++) begin
                if (a == A_PRE + t)  r_d.pre[t]  = bus_wdata;
                if (a == A_CTRL + t) r_d.ctrl[t] = bus_wdata[CTRL_W-1:0];
            end
            if (a == A_EN)   r_d.en = bus_wdata[NUM_TMR-1:0];
            if (a == A_FLAG) clr = bus_wdata[NUM_MATCH-1:0];
        end
        r_d.flag = (r_q.flag & ~clr) | hit_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read multiplexer.
    always_comb begin
        int a;
        a = int'(bus_addr);
        bus_rdata = '0;
        for (int m = 0; m < NUM_MATCH; m++) begin
            if (a == A_MATCH + m) bus_rdata = r_q.match[m];
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            if (a == A_COUNT + t) bus_rdata = cnt_all[t];
            if (a == A_SNAP + t)  bus_rdata = cap_all[t];
            if (a == A_PRE + t)   bus_rdata = r_q.pre[t];
            if (a == A_CTRL + t)  bus_rdata = CNT_W'(r_q.ctrl[t]);
        end
        if (a == A_EN)   bus_rdata = CNT_W'(r_q.en);
        if (a == A_FLAG) bus_rdata = CNT_W'(r_q.flag);
        if (a == A_PEND) bus_rdata = CNT_W'(pend_all);
    end
endmodule

// File: rtl/mtb_checker.sv
module mtb_checker #(
    parameter int CNT_W    = 32,
    parameter int NUM_TMR  = 3,
    parameter int NUM_CMP  = 3,
    parameter int ADDR_W   = 6,
    parameter int SYNC_CYC = 2,
    parameter int CTRL_W   = 2,
    parameter int A_FLAG   = 22
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_wr,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [NUM_TMR*NUM_CMP-1:0]      wbits,
    input logic [NUM_TMR-1:0]              en,
    input logic [NUM_TMR-1:0][CTRL_W-1:0]  ctrl,
    input logic [NUM_TMR-1:0][CNT_W-1:0]   cnt,
    input logic [NUM_TMR-1:0][CNT_W-1:0]   cap,
    input logic [NUM_TMR-1:0]              pend,
    input logic [NUM_TMR*NUM_CMP-1:0]      flag
);
    localparam int NUM_MATCH = NUM_TMR * NUM_CMP;

    int run_q [NUM_TMR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TMR; t++) run_q[t] <= 0;
        end else begin
            for (int t = 0; t < NUM_TMR; t++) begin
                if (!pend[t])                  run_q[t] <= 0;
                else if (run_q[t] <= SYNC_CYC) run_q[t] <= run_q[t] + 1;
            end
        end
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !en[t] |=> $stable(cnt[t]));

        p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (en[t] && ctrl[t] == '0) |=> cnt[t] == $past(cnt[t]) + CNT_W'(1));

        p_pend_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[t]) |-> run_q[t] == SYNC_CYC);

        p_cap_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cap[t]) |-> ($past(pend[t]) && !pend[t]));
    end

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_m
        p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[m]) |-> $past(bus_wr && int'(bus_addr) == A_FLAG && wbits[m]));
    end
endmodule

bind match_timer_bank mtb_checker #(
    .CNT_W(CNT_W), .NUM_TMR(NUM_TMR), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W),
    .SYNC_CYC(SYNC_CYC), .CTRL_W(CTRL_W), .A_FLAG(A_FLAG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbits    (bus_wdata[NUM_MATCH-1:0]),
    .en       (tmr_en),
    .ctrl     (tmr_ctrl),
    .cnt      (cnt_all),
    .cap      (cap_all),
    .pend     (pend_all),
    .flag     (flag_all)
);

// File: tb/match_timer_bank_bench.sv
`timescale 1ns/1ps
module match_timer_bank_bench;
    localparam int NV = 58;

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-check, 2 wait cycles
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t wv(int a, logic [31:0] d);
        return '{op: 2'd0, addr: 6'(a), data: d, exp: '0, req: 4'd0};
    endfunction
    function automatic vec_t rv(int a, logic [31:0] e, int r);
        return '{op: 2'd1, addr: 6'(a), data: '0, exp: e, req: 4'(r)};
    endfunction
    function automatic vec_t tv(int n);
        return '{op: 2'd2, addr: '0, data: 32'(n), exp: '0, req: 4'd0};
    endfunction

    localparam vec_t VECS [NV] = '{
        wv(0, 5), wv(15, 2), wv(18, 1),
        rv(18, 1, 10), rv(0, 5, 10),                       // R10 readback
        wv(21, 1), tv(9), wv(21, 0),
        rv(9, 2, 4),                                       // R4 10 steps with reload 5->2
        rv(10, 0, 5),                                      // R5 timer 1 untouched
        rv(22, 7, 6),                                      // R6 flags 0,1,2 of timer 0
        wv(22, 2), rv(22, 5, 7),                           // R7 clear bit 1
        wv(22, 0), rv(22, 5, 7),                           // R7 zero write no effect
        tv(5), rv(9, 2, 2),                                // R2 hold while stopped
        wv(18, 0), wv(21, 1), tv(3), wv(21, 0),
        rv(9, 6, 3),                                       // R3 no reload past match
        wv(12, 1), rv(23, 1, 8), rv(12, 0, 9),             // R8 pending, R9 old capture
        tv(1), rv(23, 1, 8),
        tv(1), rv(23, 0, 8), rv(12, 6, 8),                 // R8 capture complete
        wv(12, 0), rv(23, 0, 9),                           // R9 bit0 clear ignored
        wv(9, 32'h55), rv(9, 6, 9),                        // R9 live count read-only
        wv(8, 3), wv(17, 32'h10), wv(20, 3), wv(21, 4),
        wv(14, 1), tv(2), rv(14, 2, 8),                    // R8 running capture
        tv(1), wv(21, 0),
        rv(11, 32'h11, 4),                                 // R4 comparator 2 trigger
        rv(22, 32'h1C5, 6),                                // R6 timer 2 flags
        wv(4, 2), wv(16, 32'hFFFF_FFFD), wv(19, 2),
        wv(21, 2), tv(2), wv(21, 0),
        rv(10, 32'hFFFF_FFFD, 4),                          // R4 comparator 1 trigger
        wv(19, 0), wv(21, 2), tv(3), wv(21, 0),
        rv(10, 1, 3),                                      // R3 wrap to zero
        rv(9, 6, 5)                                        // R5 timer 0 unaffected
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    match_timer_bank u_match_timer_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic chk(input logic [5:0] a, input logic [31:0] e, input int r);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL R%0d addr %0d: got %h expected %h", r, a, bus_rdata, e);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1 reset state
        for (int a = 0; a < 24; a++) chk(6'(a), 32'h0, 1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: wr(VECS[i].addr, VECS[i].data);
                2'd1: chk(VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
                default: begin
                    repeat (int'(VECS[i].data)) @(posedge clk);
                    #1;
                end
            endcase
        end

        // R1 reset in the middle of operation, with a capture pending
        wr(6'd21, 32'h7);
        wr(6'd13, 32'h1);
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk(6'd11, 32'h0, 1);
        chk(6'd21, 32'h0, 1);
        chk(6'd22, 32'h0, 1);
        chk(6'd23, 32'h0, 1);
        chk(6'd14, 32'h0, 1);
        chk(6'd0,  32'h0, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule